// File: doc/BRIEF.md
# Store Drain Buffer for a Write-Through Data Cache

This block holds stores on their way from a write-through, no-write-allocate data cache to the next memory level. Every store the processor issues is pushed into a small queue, whether it hit the cache or not. The processor goes on at once unless the queue has no free slot. The queue hands its oldest entry to memory through a valid/acknowledge handshake and retires one entry per acknowledge.

A store that missed the cache does not allocate a line. Instead, the buffer raises an invalidate strobe with the cache index taken from the store address, so the cache array drops the line that the store left stale. When the cache misses on a load, the requested word address is compared against every pending entry before memory is read. The youngest matching entry supplies the data if its byte lanes cover the request. If that entry lacks some requested lane, the load is told to wait until the entry has drained. An empty flag lets ordering logic hold off until all stores have left.

Top module: `wt_store_buffer`

## Requirements
- R1: While reset is applied and just after it, `buf_empty` is 1, `mem_valid` is 0 and `st_stall` is 0.
- R2: A store offered while a slot is free is taken in that cycle without stall. This holds for cache hits (`st_hit`=1) and misses alike, and the store later reaches the memory side.
- R3: Entries leave in the order they were taken, one per cycle with `mem_valid` and `mem_ack` both high. While `mem_ack` is low, `mem_addr`, `mem_data` and `mem_be` hold their values.
- R4: `st_stall` is 1 only when all DEPTH slots are occupied and no acknowledge retires an entry in that cycle. A store offered to a full buffer in a cycle with `mem_ack` high is taken. A stalled store is not recorded and never reaches memory.
- R5: A store taken with `st_hit`=0 raises `inv_valid` in the same cycle, with `inv_index` equal to `st_addr[OFF_W+IDX_W-1:OFF_W]` (bits 5:2 by default). Stores that hit, and stores that stall, leave `inv_valid` low.
- R6: With `rd_valid` high, entries whose address matches `rd_addr` above the byte offset (bits 15:2 by default) are compared. If the youngest match has every lane of `rd_be` set in its byte enables, `rd_fwd` is 1 and `rd_data` carries that entry's data.
- R7: If the youngest matching entry lacks a requested lane, `rd_wait` is 1 and `rd_fwd` is 0. This holds even when an older match covers the lanes.
- R8: With no matching entry, or with `rd_valid` low, both `rd_fwd` and `rd_wait` are 0.
- R9: `buf_empty` is 1 exactly when no store is pending, and it falls in the cycle after a store is taken into an empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store offered by the cache side |
| st_hit | input | 1 | Store hit the cache (1) or missed (0) |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte-lane enables |
| st_stall | output | 1 | Store not taken this cycle; processor must hold it |
| inv_valid | output | 1 | Invalidate the cache line selected by inv_index |
| inv_index | output | IDX_W | Cache line index to invalidate |
| mem_valid | output | 1 | Oldest entry presented to memory |
| mem_addr | output | ADDR_W | Address of the oldest entry |
| mem_data | output | DATA_W | Data of the oldest entry |
| mem_be | output | DATA_W/8 | Byte enables of the oldest entry |
| mem_ack | input | 1 | Memory accepts the presented entry |
| rd_valid | input | 1 | Read-miss lookup request |
| rd_addr | input | ADDR_W | Read-miss byte address |
| rd_be | input | DATA_W/8 | Byte lanes the read needs |
| rd_fwd | output | 1 | Data forwarded from a pending store |
| rd_wait | output | 1 | Matching store covers too few lanes; wait for drain |
| rd_data | output | DATA_W | Forwarded data |
| buf_empty | output | 1 | No pending stores |

## Verification
Several properties are checked in every cycle. The occupancy count stays within DEPTH and agrees with the pointer gap. The memory-side fields stay stable while an acknowledge is missing. A stall only happens with a full queue. An invalidate only accompanies a taken miss. Forward and wait never rise together, and a buffer that takes a store is not empty in the next cycle. Only the bench scenarios can show the rest. These are the drain order against a scoreboard, the youngest-match choice when two entries share a word, and the wait outcome when an older entry would have covered the lanes. They also show the same-cycle acceptance into a full buffer and that a stalled store never appears at memory.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_FWD  = 2'd1,
    LK_WAIT = 2'd2
  } lk_res_e;

endpackage

// File: rtl/sdb_ctrl.sv
module sdb_ctrl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             full,
  output logic             empty,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] cnt
);

  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign pop_ok  = pop_req && !empty;
  // A retiring entry frees a slot in the same cycle.
  assign push_ok = push_req && (!full || pop_ok);

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (pop_ok) begin
      head_d = head_q + PTR_W'(1);
    end
    if (push_ok) begin
      tail_d = tail_q + PTR_W'(1);
    end
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_ok)           head_q <= head_d;
      if (push_ok)          tail_q <= tail_d;
      if (push_ok ^ pop_ok) cnt_q  <= cnt_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign cnt  = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R4

  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) == cnt_q[PTR_W-1:0]); // R3

endmodule

// File: rtl/sdb_store.sv
module sdb_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [PTR_W-1:0]             wslot,
  input  logic [ADDR_W-1:0]            waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [BE_W-1:0]              wbe,
  output logic [DEPTH-1:0][ADDR_W-1:0] addr_arr,
  output logic [DEPTH-1:0][DATA_W-1:0] data_arr,
  output logic [DEPTH-1:0][BE_W-1:0]   be_arr
);

  logic [DEPTH-1:0] slot_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign slot_en[g] = we && (wslot == PTR_W'(g));
  end

  // Payload registers carry no reset; occupancy lives in the controller.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_en[i]) begin
        addr_arr[i] <= waddr;
        data_arr[i] <= wdata;
        be_arr[i]   <= wbe;
      end
    end
  end

endmodule

// File: rtl/sdb_lookup.sv
module sdb_lookup
  import sdb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int OFF_W = $clog2(BE_W),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_valid,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [BE_W-1:0]              rd_be,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_arr,
  input  logic [DEPTH-1:0][DATA_W-1:0] data_arr,
  input  logic [DEPTH-1:0][BE_W-1:0]   be_arr,
  input  logic [PTR_W-1:0]             tail,
  input  logic [CNT_W-1:0]             cnt,
  output lk_res_e                      res,
  output logic [DATA_W-1:0]            fwd_data
);

  logic             found;
  logic [PTR_W-1:0] sel;
  logic [PTR_W-1:0] slot;
  logic             covers;

  // Walk from the youngest entry toward the oldest; the first hit wins.
  always_comb begin
    found = 1'b0;
    sel   = '0;
    slot  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = PTR_W'(int'(tail) + DEPTH - 1 - k);
      if (!found && (k < int'(cnt)) &&
          (addr_arr[slot][ADDR_W-1:OFF_W] == rd_addr[ADDR_W-1:OFF_W])) begin
        found = 1'b1;
        sel   = slot;
      end
    end
  end

  assign covers   = ((be_arr[sel] & rd_be) == rd_be);
  assign fwd_data = data_arr[sel];

  always_comb begin
    if (!rd_valid || !found) begin
      res = LK_NONE;
    end else if (covers) begin
      res = LK_FWD;
    end else begin
      res = LK_WAIT;
    end
  end

  AST_LOOKUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid || cnt == '0) |-> res == LK_NONE); // R8

  AST_FWD_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    res == LK_FWD |-> (be_arr[sel] | ~rd_be) == {BE_W{1'b1}}); // R6

endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer
  import sdb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int OFF_W = $clog2(BE_W),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic              st_hit,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  output logic              st_stall,
  output logic              inv_valid,
  output logic [IDX_W-1:0]  inv_index,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_ack,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BE_W-1:0]   rd_be,
  output logic              rd_fwd,
  output logic              rd_wait,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_empty
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic                         push_ok, pop_ok, full, empty;
  logic [PTR_W-1:0]             head, tail;
  logic [CNT_W-1:0]             cnt;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_arr;
  logic [DEPTH-1:0][DATA_W-1:0] data_arr;
  logic [DEPTH-1:0][BE_W-1:0]   be_arr;
  lk_res_e                      lk_res;

  sdb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .push_req (st_valid),
    .pop_req  (mem_ack),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .full     (full),
    .empty    (empty),
    .head     (head),
    .tail     (tail),
    .cnt      (cnt)
  );

  sdb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .we       (push_ok),
    .wslot    (tail),
    .waddr    (st_addr),
    .wdata    (st_data),
    .wbe      (st_be),
    .addr_arr (addr_arr),
    .data_arr (data_arr),
    .be_arr   (be_arr)
  );

  sdb_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_lookup (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_be    (rd_be),
    .addr_arr (addr_arr),
    .data_arr (data_arr),
    .be_arr   (be_arr),
    .tail     (tail),
    .cnt      (cnt),
    .res      (lk_res),
    .fwd_data (rd_data)
  );

  assign st_stall  = st_valid && !push_ok;
  assign inv_valid = push_ok && !st_hit;
  assign inv_index = st_addr[OFF_W +: IDX_W];

  assign mem_valid = !empty;
  assign mem_addr  = addr_arr[head];
  assign mem_data  = data_arr[head];
  assign mem_be    = be_arr[head];

  assign rd_fwd    = (lk_res == LK_FWD);
  assign rd_wait   = (lk_res == LK_WAIT);
  assign buf_empty = empty;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) &&
                              $stable(mem_data) && $stable(mem_be)); // R3

  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!core_rst_n)
    st_stall |-> cnt == CNT_W'(DEPTH) && !mem_ack); // R4

  AST_INV_ON_MISS: assert property (@(posedge clk) disable iff (!core_rst_n)
    inv_valid |-> st_valid && !st_hit && !st_stall); // R5

  AST_FWD_WAIT_EXCL: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(rd_fwd && rd_wait)); // R7

  AST_EMPTY_FALLS: assert property (@(posedge clk) disable iff (!core_rst_n)
    buf_empty && st_valid && !st_stall |=> !buf_empty); // R9

endmodule

// File: tb/sim_wt_store_buffer.sv
`timescale 1ns/1ps
module sim_wt_store_buffer;

  logic        clk, rst_n;
  logic        st_valid, st_hit;
  logic [15:0] st_addr;
  logic [31:0] st_data;
  logic [3:0]  st_be;
  logic        st_stall, inv_valid;
  logic [3:0]  inv_index;
  logic        mem_valid, mem_ack;
  logic [15:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_be;
  logic        rd_valid, rd_fwd, rd_wait;
  logic [15:0] rd_addr;
  logic [3:0]  rd_be;
  logic [31:0] rd_data;
  logic        buf_empty;

  wt_store_buffer u0 (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_hit(st_hit), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
    .inv_valid(inv_valid), .inv_index(inv_index),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_be(mem_be), .mem_ack(mem_ack),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_be(rd_be),
    .rd_fwd(rd_fwd), .rd_wait(rd_wait), .rd_data(rd_data),
    .buf_empty(buf_empty)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [31:0] d;
    logic [3:0]  b;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int pops   = 0;
  int ack_mode = 0;
  bit done = 0;

  initial begin
    clk = 0;
    forever #2 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Acknowledge driver: 0 never, 1 always, 2 every other cycle.
  initial begin
    mem_ack = 0;
    forever begin
      @(posedge clk);
      #1;
      case (ack_mode)
        1:       mem_ack = 1;
        2:       mem_ack = ~mem_ack;
        default: mem_ack = 0;
      endcase
    end
  end

  // Monitor: pop expected items as memory takes them.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_valid && mem_ack) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4", "drain with nothing expected", {12'h0, mem_addr, mem_data, mem_be}, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          pops++;
          chk({mem_addr, mem_data, mem_be} == e, "R3", "drain order/content",
              {12'h0, mem_addr, mem_data, mem_be}, {12'h0, e});
        end
      end
    end
  end

  // Driver: offer a store from posedge+1, hold while stalled, push expected on acceptance.
  task automatic do_store(input logic [15:0] a, input logic [31:0] d,
                          input logic [3:0] b, input bit hit, input bit chk_inv,
                          output int stalls);
    stalls = 0;
    st_addr = a; st_data = d; st_be = b; st_hit = hit; st_valid = 1;
    forever begin
      @(negedge clk);
      if (!st_stall) begin
        exp_q.push_back({a, d, b});
        if (chk_inv) begin
          chk(inv_valid == !hit, "R5", "inv_valid on taken store", inv_valid, !hit);
          if (!hit) chk(inv_index == a[5:2], "R5", "inv_index", inv_index, a[5:2]);
        end
        break;
      end
      stalls++;
      @(posedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    st_valid = 0;
  endtask

  task automatic rd_check(input logic [15:0] a, input logic [3:0] b, input bit v,
                          input bit e_fwd, input bit e_wait, input logic [31:0] e_data,
                          input string req);
    rd_addr = a; rd_be = b; rd_valid = v;
    @(negedge clk);
    chk(rd_fwd == e_fwd, req, "rd_fwd", rd_fwd, e_fwd);
    chk(rd_wait == e_wait, req, "rd_wait", rd_wait, e_wait);
    if (e_fwd) chk(rd_data == e_data, req, "rd_data", rd_data, e_data);
    @(posedge clk);
    #1;
    rd_valid = 0;
  endtask

  task automatic wait_empty(input string req);
    int n;
    n = 0;
    while (n < 200) begin
      @(negedge clk);
      if (buf_empty) break;
      n++;
    end
    chk(buf_empty == 1, req, "buffer drained", buf_empty, 1);
    chk(mem_valid == 0, req, "mem_valid low when drained", mem_valid, 0);
    @(posedge clk);
    #1;
  endtask

  initial begin
    int s;
    logic [15:0] held;
    rst_n = 0; st_valid = 0; st_hit = 0; st_addr = 0; st_data = 0; st_be = 0;
    rd_valid = 0; rd_addr = 0; rd_be = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(buf_empty == 1, "R1", "buf_empty in reset", buf_empty, 1);
    chk(mem_valid == 0, "R1", "mem_valid in reset", mem_valid, 0);
    chk(st_stall == 0, "R1", "st_stall in reset", st_stall, 0);
    @(posedge clk); #1; rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(buf_empty == 1, "R1", "buf_empty after release", buf_empty, 1);

    // Fill with hits and a miss; no acknowledge.
    do_store(16'h0040, 32'h11111111, 4'hF, 1, 1, s);
    chk(s == 0, "R2", "stall with free slot (hit)", s, 0);
    chk(buf_empty == 0 && mem_valid == 1, "R9", "not empty after store", buf_empty, 0);
    do_store(16'h0124, 32'h22222222, 4'hF, 0, 1, s);
    chk(s == 0, "R2", "stall with free slot (miss)", s, 0);
    do_store(16'h0208, 32'h33333333, 4'hF, 1, 1, s);
    chk(s == 0, "R2", "stall with free slot", s, 0);
    do_store(16'h0040, 32'h44444444, 4'h3, 1, 1, s);
    chk(s == 0, "R2", "fourth store stall", s, 0);

    // Full, no ack: a miss must stall and must not invalidate.
    st_addr = 16'h0500; st_data = 32'h55555555; st_be = 4'hF; st_hit = 0; st_valid = 1;
    @(negedge clk);
    chk(st_stall == 1, "R4", "stall when full", st_stall, 1);
    chk(inv_valid == 0, "R5", "no invalidate on stalled miss", inv_valid, 0);
    @(posedge clk); #1; st_valid = 0;

    // Lookups
    rd_check(16'h0042, 4'h3, 1, 1, 0, 32'h44444444, "R6");
    rd_check(16'h0124, 4'h4, 1, 1, 0, 32'h22222222, "R6");
    rd_check(16'h0040, 4'hF, 1, 0, 1, 32'h0, "R7");
    rd_check(16'h0300, 4'hF, 1, 0, 0, 32'h0, "R8");
    rd_check(16'h0040, 4'h3, 0, 0, 0, 32'h0, "R8");

    // Full buffer with ack in the same cycle: store is taken.
    ack_mode = 1;
    @(posedge clk); #1;
    do_store(16'h0600, 32'h66666666, 4'hF, 1, 0, s);
    chk(s == 0, "R4", "full plus ack accepts store", s, 0);
    wait_empty("R9");
    chk(pops == 5, "R4", "stalled store never drained", pops, 5);

    // Hold while not acknowledged.
    ack_mode = 0;
    @(posedge clk); #1;
    do_store(16'h0700, 32'h77777777, 4'hF, 1, 0, s);
    do_store(16'h0704, 32'h88888888, 4'hC, 0, 1, s);
    @(negedge clk);
    held = mem_addr;
    chk(mem_addr == 16'h0700, "R3", "oldest presented first", mem_addr, 16'h0700);
    repeat (3) @(negedge clk);
    chk(mem_valid == 1 && mem_addr == held, "R3", "held without ack", mem_addr, held);
    @(posedge clk); #1;
    ack_mode = 2;
    for (int i = 0; i < 10; i++) begin
      do_store(16'h1000 + 16'(i * 4), 32'hA5000000 + 32'(i), 4'(i + 1), i[0], 1, s);
    end
    wait_empty("R3");
    chk(pops == 17, "R3", "all stores drained", pops, 17);
    chk(exp_q.size() == 0, "R2", "scoreboard empty", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule